// File: doc/BRIEF.md
# Half-Duplex Transmit Timing Controller

This block decides when a half-duplex Ethernet MAC may put a frame on the wire and when it must try again. It counts bit times from a bit-time tick, keeps the inter-frame gap, and after a collision runs the standard truncated binary exponential backoff. It drops a frame on a late collision. It can also drop a frame after sixteen collisions, if configured to do so. The data path, preamble and CRC belong to the MAC and are not part of this block.

The MAC raises `tx_req` and holds it for the length of a frame. The controller answers with `tx_en` and a one-cycle `start_stb`, or `retry_stb` for a retry. The MAC lowers `tx_req` when its last bit has gone out. The controller then drops `tx_en` and pulses `done_stb`. A collision seen on `col` while transmitting ends the attempt at once. The controller then either backs off and retries, or pulses `drop_stb` and waits for `tx_req` to go low before it accepts a new frame. `attempt_cnt` shows the number of collisions of the frame in flight.

Top module: `hd_tx_timer`

## Requirements
- R1: With `tx_req` high, `crs` low and the gap satisfied, `tx_en` rises in the next cycle with a one-cycle `start_stb` for a fresh frame. While `crs` is high, no transmission starts.
- R2: `tx_en` stays high while `tx_req` is high and no collision occurs. One cycle after `tx_req` is seen low, `tx_en` is low, `done_stb` pulses and `attempt_cnt` reads 0.
- R3: After a successful frame, the next `tx_en` rises exactly GAP_BITS+1 cycles after the falling edge of the previous one when `bit_tick` is held high. The gap counts from the end of `tx_en`.
- R4: A collision drops `tx_en` in the next cycle. The retry's `tx_en` rises no earlier than GAP_BITS+1 bit times after `crs` falls, and carrier seen during the wait restarts the gap.
- R5: After collision number n, the controller waits k slots of SLOT_BITS bit times before retrying, with k drawn from 0 to 2^min(n,BACKOFF_LIMIT)-1. The retry starts with `retry_stb`, and `attempt_cnt` reads n (modulo 16).
- R6: With `aggressive` high, the backoff exponent is capped at AGGR_LIMIT.
- R7: With `drop_excess` high, the 16th collision of a frame gives `drop_stb` with no retry and sets `attempt_cnt` to 0. `tx_en` stays low until `tx_req` has been low.
- R8: With `drop_excess` low, the 16th collision sets `attempt_cnt` back to 0 and retries continue.
- R9: A collision more than SLOT_BITS bit times into the transmission gives `drop_stb` with no retry. A collision at exactly SLOT_BITS is retried.
- R10: After reset, `tx_en`, all strobes and `attempt_cnt` are 0. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per bit time |
| tx_req | input | 1 | MAC holds a frame to send; low marks the end of the frame |
| col | input | 1 | Collision detected on the medium |
| crs | input | 1 | Carrier sense |
| aggressive | input | 1 | Cap the backoff exponent at AGGR_LIMIT |
| drop_excess | input | 1 | Drop the frame on its 16th collision |
| tx_en | output | 1 | Transmit enable to the PHY |
| start_stb | output | 1 | First attempt of a frame began |
| retry_stb | output | 1 | Retry after backoff began |
| drop_stb | output | 1 | Frame abandoned (late or excessive collision) |
| done_stb | output | 1 | Frame sent successfully |
| attempt_cnt | output | 4 | Collisions of the current frame |

## Verification
On every cycle, the assertions check these properties: strobes are exclusive, a transmission starts only on a request with an idle line, and `tx_en` ends only on a collision or the end of a request. They also check that a late or sixteenth collision leads to a drop, and that aggressive mode draws slot counts below its cap. Several properties need the bench's scenarios: the exact gap after a successful frame, the gap counted from the fall of carrier after a collision, the upper bound on each backoff delay, the counter wrap with retries continuing, and the late-collision boundary at exactly SLOT_BITS.

// File: rtl/hd_tx_timer.sv
module hd_tx_timer #(
  parameter int GAP_BITS      = 96,
  parameter int SLOT_BITS     = 512,
  parameter int BACKOFF_LIMIT = 10,
  parameter int AGGR_LIMIT    = 3,
  parameter int MAX_COLL      = 16,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_req,
  input  logic col,
  input  logic crs,
  input  logic aggressive,
  input  logic drop_excess,
  output logic tx_en,
  output logic start_stb,
  output logic retry_stb,
  output logic drop_stb,
  output logic done_stb,
  output logic [$clog2(MAX_COLL)-1:0] attempt_cnt
);
  localparam int AW = $clog2(MAX_COLL);
  localparam int EW = AW + 1;
  localparam int BW = BACKOFF_LIMIT;
  localparam int GW = $clog2(GAP_BITS + 1);
  localparam int SW = $clog2(SLOT_BITS + 2);
  localparam logic [GW-1:0] GAP_V  = GW'(GAP_BITS);
  localparam logic [SW-1:0] SLOT_V = SW'(SLOT_BITS);
  localparam logic [SW-1:0] SUB_LAST = SW'(SLOT_BITS - 1);
  localparam logic [EW-1:0] MAX_V  = EW'(MAX_COLL);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_BACK, S_HOLD} state_t;

  state_t state;
  logic [GW-1:0] gap_cnt;
  logic [SW-1:0] tx_bits, sub_cnt;
  logic [BW-1:0] slots_left;
  logic [AW-1:0] attempts;
  logic [15:0] lfsr;
  logic after_col, retrying;

  logic gap_ok, can_go, late, hit_max;
  logic [EW-1:0] coll_n, lim, expo;
  logic [BW:0] span;

  assign gap_ok  = gap_cnt == GAP_V;
  assign can_go  = state == S_IDLE && tx_req && !crs && gap_ok;
  assign late    = tx_bits > SLOT_V;
  assign coll_n  = {1'b0, attempts} + EW'(1);
  assign hit_max = coll_n == MAX_V;
  assign lim     = aggressive ? EW'(AGGR_LIMIT) : EW'(BACKOFF_LIMIT);
  assign expo    = (coll_n < lim) ? coll_n : lim;
  assign span    = ((BW+1)'(1) << expo) - (BW+1)'(1);

  assign tx_en       = state == S_TX;
  assign attempt_cnt = attempts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      gap_cnt <= GAP_V;
      tx_bits <= '0;
      sub_cnt <= '0;
      slots_left <= '0;
      attempts <= '0;
      lfsr <= SEED;
      after_col <= 1'b0;
      retrying <= 1'b0;
      start_stb <= 1'b0;
      retry_stb <= 1'b0;
      drop_stb <= 1'b0;
      done_stb <= 1'b0;
    end else begin
      start_stb <= 1'b0;
      retry_stb <= 1'b0;
      drop_stb <= 1'b0;
      done_stb <= 1'b0;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[14] ^ lfsr[12] ^ lfsr[3]};

      if (state == S_TX || (after_col && crs)) gap_cnt <= '0;
      else if (bit_tick && !gap_ok) gap_cnt <= gap_cnt + GW'(1);

      case (state)
        S_IDLE: if (can_go) begin
          state <= S_TX;
          tx_bits <= '0;
          after_col <= 1'b0;
          retrying <= 1'b0;
          if (retrying) retry_stb <= 1'b1;
          else start_stb <= 1'b1;
        end
        S_TX: begin
          if (bit_tick && !late) tx_bits <= tx_bits + SW'(1);
          if (col) begin
            after_col <= 1'b1;
            if (late || (hit_max && drop_excess)) begin
              drop_stb <= 1'b1;
              attempts <= '0;
              state <= S_HOLD;
            end else begin
              attempts <= hit_max ? '0 : coll_n[AW-1:0];
              slots_left <= lfsr[BW-1:0] & span[BW-1:0];
              sub_cnt <= '0;
              retrying <= 1'b1;
              state <= S_BACK;
            end
          end else if (!tx_req) begin
            done_stb <= 1'b1;
            attempts <= '0;
            state <= S_IDLE;
          end
        end
        S_BACK: begin
          if (slots_left == '0) state <= S_IDLE;
          else if (bit_tick) begin
            if (sub_cnt == SUB_LAST) begin
              sub_cnt <= '0;
              slots_left <= slots_left - BW'(1);
            end else sub_cnt <= sub_cnt + SW'(1);
          end
        end
        default: if (!tx_req) state <= S_IDLE;
      endcase
    end
  end

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_stb, retry_stb, drop_stb, done_stb}));

  a_r1_start_on_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(tx_req && !crs));

  a_r2_end_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> ($past(col) || !$past(tx_req)));

  a_r9_late_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TX && col && late) |=> (drop_stb && !tx_en));

  a_r7_excess_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TX && col && !late && hit_max && drop_excess) |=> (drop_stb && attempt_cnt == '0));

  a_r6_aggr_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TX && col && !late && aggressive && !(hit_max && drop_excess))
      |=> ({1'b0, slots_left} < (BW+1)'(1 << AGGR_LIMIT)));
endmodule

// File: tb/sim_hd_tx_timer.sv
module sim_hd_tx_timer;
  localparam int GAP = 12;
  localparam int SLOT = 8;
  localparam int EV_START = 1, EV_RETRY = 2, EV_DROP = 3, EV_DONE = 4;

  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b1;
  logic tx_req = 1'b0, col = 1'b0, crs = 1'b0, aggressive = 1'b0, drop_excess = 1'b0;
  logic tx_en, start_stb, retry_stb, drop_stb, done_stb;
  logic [3:0] attempt_cnt;

  int cyc = 0, checks = 0, fails = 0, last_fall = 0;
  bit have_fall = 0, finished = 0;
  int exp_q[$];

  hd_tx_timer #(.GAP_BITS(GAP), .SLOT_BITS(SLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_req(tx_req), .col(col), .crs(crs),
    .aggressive(aggressive), .drop_excess(drop_excess), .tx_en(tx_en), .start_stb(start_stb),
    .retry_stb(retry_stb), .drop_stb(drop_stb), .done_stb(done_stb), .attempt_cnt(attempt_cnt));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (start_stb || retry_stb || drop_stb || done_stb)) begin
      int got;
      got = start_stb ? EV_START : retry_stb ? EV_RETRY : drop_stb ? EV_DROP : EV_DONE;
      chk($countones({start_stb, retry_stb, drop_stb, done_stb}) == 1, "R10 one strobe",
          $countones({start_stb, retry_stb, drop_stb, done_stb}), 1);
      if (exp_q.size() == 0) chk(0, "R10 unexpected strobe", got, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(got == e, "R5/R7/R9 strobe order", got, e);
      end
    end
  end

  task automatic wait_tx(output int t);
    t = -1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (tx_en) begin t = cyc; break; end
    end
    if (t < 0) chk(0, "R5 retry never started", 0, 1);
  endtask

  task automatic run_frame(int ncol, int col_at, bit late_end, bit aggr, bit dropx);
    int t, tcol, tcrs, n, e;
    bit dropping, dropped;
    dropped = 0;
    aggressive = aggr;
    drop_excess = dropx;
    @(negedge clk);
    tx_req = 1'b1;
    exp_q.push_back(EV_START);
    wait_tx(t);
    if (have_fall) chk(t - last_fall == GAP + 1, "R3 gap after success", t - last_fall, GAP + 1);
    for (int i = 1; i <= ncol && !dropped; i++) begin
      repeat (col_at) @(negedge clk);
      n = ((i - 1) % 16) + 1;
      dropping = (i == ncol) && (late_end || (dropx && n == 16));
      exp_q.push_back(dropping ? EV_DROP : EV_RETRY);
      col = 1'b1; crs = 1'b1; tcol = cyc;
      @(negedge clk);
      col = 1'b0;
      chk(!tx_en, "R4 collision ends tx_en", tx_en, 0);
      if (dropping) begin
        chk(attempt_cnt == 0, late_end ? "R9 drop count" : "R7 drop count", attempt_cnt, 0);
        repeat (3) @(negedge clk);
        crs = 1'b0;
        for (int k = 0; k < 30; k++) begin
          @(negedge clk);
          if (k == 29) chk(!tx_en, late_end ? "R9 no retry" : "R7 no retry", tx_en, 0);
        end
        tx_req = 1'b0;
        dropped = 1;
        have_fall = 0;
      end else begin
        repeat (3) @(negedge clk);
        crs = 1'b0; tcrs = cyc;
        wait_tx(t);
        chk(t - tcrs >= GAP + 1, "R4 gap from carrier fall", t - tcrs, GAP + 1);
        e = (n < (aggr ? 3 : 10)) ? n : (aggr ? 3 : 10);
        chk(t - tcol <= ((1 << e) - 1) * SLOT + GAP + 8, aggr ? "R6 aggressive bound" : "R5 backoff bound",
            t - tcol, ((1 << e) - 1) * SLOT + GAP + 8);
        chk(attempt_cnt == 4'(n % 16), n == 16 ? "R8 count wraps" : "R5 attempt count", attempt_cnt, n % 16);
      end
    end
    if (!dropped) begin
      repeat (6) @(negedge clk);
      chk(tx_en, "R2 tx_en held", tx_en, 1);
      exp_q.push_back(EV_DONE);
      tx_req = 1'b0;
      @(negedge clk);
      chk(!tx_en, "R2 tx_en falls at end", tx_en, 0);
      chk(attempt_cnt == 0, "R2 count cleared", attempt_cnt, 0);
      last_fall = cyc;
      have_fall = 1;
    end
    @(negedge clk);
  endtask

  initial begin
    int t, tc;
    repeat (3) @(negedge clk);
    chk(!tx_en && !start_stb && !retry_stb && !drop_stb && !done_stb, "R10 reset outputs", tx_en, 0);
    chk(attempt_cnt == 0, "R10 reset count", attempt_cnt, 0);
    rst_n = 1'b1;
    run_frame(0, 3, 0, 0, 0);
    run_frame(0, 3, 0, 0, 0);
    run_frame(3, 3, 0, 0, 0);
    run_frame(1, SLOT, 0, 0, 0);
    run_frame(1, SLOT + 1, 1, 0, 0);
    run_frame(6, 3, 0, 1, 0);
    run_frame(16, 3, 0, 0, 1);
    run_frame(18, 3, 0, 1, 0);
    repeat (GAP + 4) @(negedge clk);
    crs = 1'b1;
    tx_req = 1'b1;
    exp_q.push_back(EV_START);
    repeat (10) @(negedge clk);
    chk(!tx_en, "R1 defers on carrier", tx_en, 0);
    crs = 1'b0; tc = cyc;
    wait_tx(t);
    chk(t - tc <= 2, "R1 starts after carrier", t - tc, 2);
    exp_q.push_back(EV_DONE);
    tx_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all strobes seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog expired", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule